// File: doc/BRIEF.md
# GPIO Edge Timestamp Capture

This block watches a small group of general-purpose input pins. When an edge that software has armed arrives on one of them, the block records the running time of day, as 32 bits of seconds and 30 bits of nanoseconds. Each pin has two independent stores, one for rising edges and one for falling edges. A per-pin status bit records the polarity of the most recent capture, so software knows which store holds the newest stamp.

Software works through a 16-bit register port. It arms edges in an enable register and picks a pin through a select window. It then reads that pin's stamps as 16-bit halves. One interrupt flag is set by any capture and is cleared when software reads it. An interrupt enable bit gates that flag onto the `irq` output.

Software handles an interrupt by reading the flag register, reading the status register, and then reading the store that the status bit points to. It reads the flag register again until the flag is clear. The register port is a plain control interface: every access finishes in one cycle, so it has no back-pressure. The pins and the time input are sampled every cycle without a handshake.

Top module: `gpio_edge_stamp`

## Requirements
- R1: After reset, every readable register (addresses 0 to 15) reads 0 and `irq` is low.
- R2: In the enable register (address 0), bit n arms rising-edge capture on pin n and bit n+8 arms falling-edge capture on pin n. An edge that is not armed captures nothing: it changes no store, no status bit and no flag.
- R3: A pin change applied between two clock edges is recorded on the third rising clock edge after it. That is two synchronizer stages plus one detection stage. The stored value is the `tod_sec`/`tod_ns` present just before that edge.
- R4: In the status register (address 1), bit n is set by a rising capture on pin n and cleared by a falling capture on pin n. It is read-only.
- R5: The select register (address 2) holds the pin number in bits 10:8. The rising store of the selected pin reads at addresses 8 to 11: seconds high, seconds low, nanoseconds high, nanoseconds low. The falling store reads at addresses 12 to 15 in the same order. Bits 15:14 of a nanoseconds-high word read 0.
- R6: A new capture of the same pin and polarity overwrites the earlier stamp in that store.
- R7: Bit 2 of the flag register (address 3) is set by any capture. A read returns the current value and clears the flag. A capture in the same cycle as the read wins, so the flag stays set.
- R8: `irq` is high exactly while the flag (address 3, bit 2) and the interrupt enable (address 4, bit 2) are both set.
- R9: Writing the select register back to 0 leaves every store unchanged, and the store windows then return pin 0's stamps.
- R10: A read returns its data on `reg_rdata` after the clock edge on which `reg_rd` was sampled. `reg_rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Asynchronous input pins |
| tod_sec | input | 32 | Running time of day, seconds |
| tod_ns | input | 30 | Running time of day, nanoseconds |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data, registered |
| irq | output | 1 | Capture interrupt |

## Verification
The assertions take three things for granted about the inputs. Each pin level is held for at least three clock cycles, so the synchronizer sees every edge. `reg_rd` and `reg_wr` are never both high. The time inputs are sampled only as data, so the assertions make no assumption about how they advance. The stimulus changes pins and strobes only on falling clock edges and holds each pin level for five cycles or more. It keeps the time value constant during a capture, except in one test that steps it every cycle to measure the capture cycle.

// File: rtl/estamp_pkg.sv
package estamp_pkg;

  localparam int SEC_W = 32;
  localparam int NS_W  = 30;
  localparam int REG_W = 16;
  localparam int ADR_W = 4;

  // Register addresses
  localparam logic [ADR_W-1:0] A_ARM    = 4'h0;
  localparam logic [ADR_W-1:0] A_STAT   = 4'h1;
  localparam logic [ADR_W-1:0] A_SEL    = 4'h2;
  localparam logic [ADR_W-1:0] A_FLAG   = 4'h3;
  localparam logic [ADR_W-1:0] A_IEN    = 4'h4;
  localparam logic [ADR_W-1:0] A_RISE_0 = 4'h8;
  localparam logic [ADR_W-1:0] A_FALL_0 = 4'hC;

  localparam int FLAG_BIT = 2;
  localparam int FALL_OFS = 8;
  localparam int SEL_LSB  = 8;
  localparam int SEL_W    = 3;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } stamp_t;

  // One 16-bit quarter of a stamp: 0 sec hi, 1 sec lo, 2 ns hi, 3 ns lo
  function automatic logic [REG_W-1:0] stamp_word(stamp_t s, logic [1:0] q);
    logic [REG_W-1:0] w;
    case (q)
      2'd0:    w = s.sec[SEC_W-1:16];
      2'd1:    w = s.sec[15:0];
      2'd2:    w = {{(2*REG_W-NS_W){1'b0}}, s.ns[NS_W-1:16]};
      default: w = s.ns[15:0];
    endcase
    return w;
  endfunction

endpackage

// File: rtl/estamp_edge_det.sv
module estamp_edge_det #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  output logic [NPINS-1:0] rise,
  output logic [NPINS-1:0] fall
);

  logic [NPINS-1:0] meta_q, sync_q, prev_q;

  // Two synchronizer stages, then one stage of history for edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_chk
      // R3: a rising edge is reported two cycles after the pin was sampled high
      p_rise_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise[i] |-> $past(pins[i], 2));
      p_fall_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall[i] |-> !$past(pins[i], 2));
    end
  endgenerate

endmodule

// File: rtl/estamp_bank.sv
module estamp_bank
  import estamp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  stamp_t stamp_in,
  output stamp_t stamp_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) stamp_q <= '0;
    else if (load) stamp_q <= stamp_in;
  end

  // R3 and R6: a load takes the presented time, including over an older stamp
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> stamp_q == $past(stamp_in));
  // R2: with no load the store keeps its stamp
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(stamp_q));

endmodule

// File: rtl/gpio_edge_stamp.sv
module gpio_edge_stamp
  import estamp_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [31:0]      tod_sec,
  input  logic [29:0]      tod_ns,
  input  logic [3:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [15:0]      reg_wdata,
  input  logic             reg_rd,
  output logic [15:0]      reg_rdata,
  output logic             irq
);

  localparam int UNUSED_STAT = REG_W - NPINS;

  // Edge detection
  logic [NPINS-1:0] rise, fall, rise_hit, fall_hit;

  estamp_edge_det #(.NPINS(NPINS)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pins (pin_in),
    .rise (rise),
    .fall (fall)
  );

  // Control state
  logic [REG_W-1:0] arm_q;
  logic [SEL_W-1:0] sel_q;
  logic [NPINS-1:0] stat_q;
  logic             flag_q;
  logic             ien_q;
  logic             cap_any;
  logic             flag_rd;

  assign rise_hit = rise & arm_q[NPINS-1:0];
  assign fall_hit = fall & arm_q[FALL_OFS +: NPINS];
  assign cap_any  = |{rise_hit, fall_hit};
  assign flag_rd  = reg_rd && (reg_addr == A_FLAG);

  // Stamp stores, one rising and one falling store per pin
  stamp_t now;
  stamp_t rise_st [NPINS];
  stamp_t fall_st [NPINS];

  assign now = '{sec: tod_sec, ns: tod_ns};

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      estamp_bank u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rise_hit[i]),
        .stamp_in(now),
        .stamp_q (rise_st[i])
      );
      estamp_bank u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (fall_hit[i]),
        .stamp_in(now),
        .stamp_q (fall_st[i])
      );

      always_ff @(posedge clk) begin
        if (!rst_n)           stat_q[i] <= 1'b0;
        else if (rise_hit[i]) stat_q[i] <= 1'b1;
        else if (fall_hit[i]) stat_q[i] <= 1'b0;
      end

      // R4: status follows the polarity of the latest capture
      p_stat_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_hit[i] |=> stat_q[i]);
      p_stat_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_hit[i] |=> !stat_q[i]);
    end
  endgenerate

  // Writable registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q <= '0;
      sel_q <= '0;
      ien_q <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_ARM:   arm_q <= reg_wdata;
        A_SEL:   sel_q <= reg_wdata[SEL_LSB +: SEL_W];
        A_IEN:   ien_q <= reg_wdata[FLAG_BIT];
        default: ;
      endcase
    end
  end

  // Capture flag: a capture beats a clearing read
  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (cap_any) flag_q <= 1'b1;
    else if (flag_rd) flag_q <= 1'b0;
  end

  assign irq = flag_q & ien_q;

  // Read path: stores of the selected pin
  stamp_t sel_rise, sel_fall;

  always_comb begin
    sel_rise = '0;
    sel_fall = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (int'(sel_q) == i) begin
        sel_rise = rise_st[i];
        sel_fall = fall_st[i];
      end
    end
  end

  logic [REG_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_ARM:   rd_mux = arm_q;
      A_STAT:  rd_mux = {{UNUSED_STAT{1'b0}}, stat_q};
      A_SEL:   rd_mux = {{(REG_W-SEL_LSB-SEL_W){1'b0}}, sel_q, {SEL_LSB{1'b0}}};
      A_FLAG:  rd_mux = REG_W'(flag_q) << FLAG_BIT;
      A_IEN:   rd_mux = REG_W'(ien_q) << FLAG_BIT;
      default: begin
        if (reg_addr[3:2] == A_RISE_0[3:2])
          rd_mux = stamp_word(sel_rise, reg_addr[1:0]);
        else if (reg_addr[3:2] == A_FALL_0[3:2])
          rd_mux = stamp_word(sel_fall, reg_addr[1:0]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R7: a capture always leaves the flag set
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_any |=> flag_q);
  // R7: a read with no capture in the same cycle clears the flag
  p_flag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !cap_any) |=> !flag_q);
  // R7: the flag only rises after a capture
  p_flag_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(cap_any));
  // R8: the interrupt follows the flag once it is enabled
  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_any && ien_q && !reg_wr) |=> irq);
  // R2: with nothing armed the status does not move
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q == '0) |=> $stable(stat_q));
  // R10: read data holds between reads
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

endmodule

// File: tb/gpio_edge_stamp_test.sv
module gpio_edge_stamp_test;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic [31:0]   tod_sec = '0;
  logic [29:0]   tod_ns = '0;
  logic [3:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [15:0]   reg_wdata = '0;
  logic          reg_rd = 1'b0;
  logic [15:0]   reg_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_edge_stamp #(.NPINS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tod_sec(tod_sec), .tod_ns(tod_ns),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  pin;
    logic        lvl;
    logic [15:0] arm;
    logic [31:0] sec;
    logic [29:0] ns;
    logic        hit;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 1'b1, 16'h0001, 32'h1234_5678, 30'h2ABC_DEF0, 1'b1},
    '{2'd0, 1'b0, 16'h0001, 32'h0000_0011, 30'h0000_0022, 1'b0},
    '{2'd1, 1'b1, 16'h0202, 32'hDEAD_0001, 30'h3FFF_FFFF, 1'b1},
    '{2'd1, 1'b0, 16'h0202, 32'hDEAD_0002, 30'h0000_0005, 1'b1},
    '{2'd2, 1'b1, 16'h0400, 32'h0000_0444, 30'h1111_1111, 1'b0},
    '{2'd2, 1'b0, 16'h0400, 32'h5555_AAAA, 30'h0F0F_0F0F, 1'b1},
    '{2'd0, 1'b1, 16'h0001, 32'h8000_0000, 30'h0000_0001, 1'b1},
    '{2'd3, 1'b1, 16'h0000, 32'h7777_7777, 30'h2222_2222, 1'b0}
  };

  // Reference model built from the requirements
  logic [31:0]   m_rs [NP];
  logic [29:0]   m_rn [NP];
  logic [31:0]   m_fs [NP];
  logic [29:0]   m_fn [NP];
  logic [NP-1:0] m_stat = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_store(input int pin, input bit falling,
                          output logic [31:0] sec, output logic [29:0] ns);
    logic [15:0] w0, w1, w2, w3;
    logic [3:0] base;
    base = falling ? 4'hC : 4'h8;
    wr(4'h2, 16'(pin) << 8);
    rd(base, w0); rd(base + 4'd1, w1); rd(base + 4'd2, w2); rd(base + 4'd3, w3);
    sec = {w0, w1};
    ns = {w2[13:0], w3};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] s;
    logic [29:0] n;
    for (int i = 0; i < NP; i++) begin
      m_rs[i] = '0; m_rn[i] = '0; m_fs[i] = '0; m_fn[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 irq", 32'(irq), 32'd0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk("R1 reg", 32'(d), 32'd0);
    end

    wr(4'h4, 16'h0004);

    // Vector walk
    for (int v = 0; v < 8; v++) begin
      wr(4'h0, VEC[v].arm);
      tod_sec = VEC[v].sec;
      tod_ns = VEC[v].ns;
      @(negedge clk);
      pin_in[VEC[v].pin] = VEC[v].lvl;
      repeat (5) @(negedge clk);
      if (VEC[v].hit) begin
        m_stat[VEC[v].pin] = VEC[v].lvl;
        if (VEC[v].lvl) begin
          m_rs[VEC[v].pin] = VEC[v].sec; m_rn[VEC[v].pin] = VEC[v].ns;
        end else begin
          m_fs[VEC[v].pin] = VEC[v].sec; m_fn[VEC[v].pin] = VEC[v].ns;
        end
      end
      chk("R8 irq", 32'(irq), 32'(VEC[v].hit));
      rd(4'h3, d);
      chk("R7 flag", 32'(d), VEC[v].hit ? 32'd4 : 32'd0);
      rd(4'h3, d);
      chk("R7 clear on read", 32'(d), 32'd0);
      rd(4'h1, d);
      chk("R4 status", 32'(d), 32'(m_stat));
      rd_store(VEC[v].pin, 1'b0, s, n);
      chk("R2 R6 rise sec", s, m_rs[VEC[v].pin]);
      chk("R2 R6 rise ns", 32'(n), 32'(m_rn[VEC[v].pin]));
      rd_store(VEC[v].pin, 1'b1, s, n);
      chk("R2 R6 fall sec", s, m_fs[VEC[v].pin]);
      chk("R2 R6 fall ns", 32'(n), 32'(m_fn[VEC[v].pin]));
    end

    // R3: capture cycle with a time value that steps every cycle
    wr(4'h4, 16'h0000);
    wr(4'h0, 16'h0800);
    @(negedge clk);
    pin_in[3] = 1'b0; tod_sec = 32'd100; tod_ns = 30'd100;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      tod_sec = 32'(100 + k); tod_ns = 30'(100 + k);
    end
    repeat (3) @(negedge clk);
    rd_store(3, 1'b1, s, n);
    chk("R3 capture sec", s, 32'd102);
    chk("R3 capture ns", 32'(n), 32'd102);
    // R8: flag set but interrupt disabled
    chk("R8 irq masked", 32'(irq), 32'd0);
    rd(4'h3, d);
    chk("R7 flag masked", 32'(d), 32'd4);
    rd(4'h3, d);
    chk("R7 cleared", 32'(d), 32'd0);
    rd(4'h1, d);
    chk("R4 status fall", 32'(d), 32'(m_stat));

    // R5: raw nanoseconds-high word of pin 1 rising store, top bits zero
    wr(4'h2, 16'h0100);
    rd(4'hA, d);
    chk("R5 ns hi", 32'(d), 32'h3FFF);
    rd(4'h2, d);
    chk("R5 select readback", 32'(d), 32'h0100);

    // R9: select back to zero returns pin 0 stamps
    wr(4'h2, 16'h0200);
    wr(4'h2, 16'h0000);
    rd(4'h8, d);
    chk("R9 sec hi", 32'(d), 32'h8000);
    rd(4'hB, d);
    chk("R9 ns lo", 32'(d), 32'h0001);

    // R10: data holds with no read strobe
    repeat (3) @(negedge clk);
    chk("R10 hold", 32'(reg_rdata), 32'h0001);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule